// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block multiplies two 32-bit operands over a number of clock cycles and returns the 64-bit product as an upper word and a lower word. It handles signed two's complement operands directly. Each cycle it looks at one bit of the multiplier together with the bit to its right, and from that pair it adds the multiplicand, subtracts it, or leaves the partial product as it is. The combined partial-product and multiplier register then shifts right arithmetically by one place. A zero is placed to the right of the multiplier's least significant bit before the first step.

A one-cycle `start` pulse loads both operands and the mode. `busy` stays high while steps run. `done` pulses for one cycle when the product is ready. In unsigned mode both operands are zero-extended by one bit, and one extra step runs so that a set top bit is weighted positively. The product words keep their value until the next accepted start. The block takes its reset asynchronously and releases it synchronously.

Top module: `booth_mult_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no start yet, `busy` and `done` are 0 and `prod_hi`/`prod_lo` are both zero.
- R2: A `start` sampled high while `busy` is low sets `busy` on that same clock edge. A `start` sampled while `busy` is high is ignored: it changes neither the result nor the timing of the run in progress, and it produces no extra `done`.
- R3: With `mode_unsigned`=0, `{prod_hi,prod_lo}` equals the 64-bit two's complement product of `op_a` and `op_b`.
- R4: With `mode_unsigned`=1, `{prod_hi,prod_lo}` equals the unsigned product of `op_a` and `op_b`.
- R5: `done` is high in the cycle after the Nth rising edge that follows the edge which accepted start. N is 32 in signed mode and 33 in unsigned mode.
- R6: `done` lasts exactly one cycle, `busy` is low whenever `done` is high, and every rise of `done` directly follows a cycle with `busy` high.
- R7: From the `done` cycle until the next accepted start, `prod_hi` and `prod_lo` do not change, whatever the operand inputs do.
- R8: `op_a`, `op_b` and `mode_unsigned` are sampled only on the edge that accepts start. Changing them during a run does not alter its result.
- R9: Extreme operands give exact results. In signed mode this includes the most negative value times itself, times -1 and times the most positive value. In unsigned mode this includes all-ones times all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin a multiplication (accepted only when idle) |
| mode_unsigned | input | 1 | 1 treats both operands as unsigned, 0 as two's complement |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier |
| busy | output | 1 | High while recoding steps are running |
| done | output | 1 | One-cycle pulse when the product is valid |
| prod_hi | output | 32 | Upper 32 bits of the product |
| prod_lo | output | 32 | Lower 32 bits of the product |

## Verification
The checks rely on a few assumptions about the inputs. `start` is treated as a synchronous input that matters only while the block is idle. The cycle counter in the checker therefore restarts only on an accepted start. The product is assumed to stay stable only when no start is accepted, and reset is taken from the internally synchronised signal. The stimulus honours these assumptions. It drives every input on the falling edge and holds `start` for exactly one cycle. It waits until the synchronised reset has been released before the first start. During runs it deliberately scrambles the operands and the mode, and pulses `start`, to exercise the ignore and sampling rules.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } booth_state_e;

endpackage

// File: rtl/booth_rst_sync.sv
module booth_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_bit,
  input  logic      prev_bit,
  output booth_op_e op
);
  always_comb begin
    unique case ({cur_bit, prev_bit})
      2'b10:   op = OP_SUB;
      2'b01:   op = OP_ADD;
      default: op = OP_NONE;
    endcase
  end
endmodule

// File: rtl/booth_step.sv
module booth_step
  import booth_pkg::*;
#(
  parameter int AW = 34,
  parameter int QW = 33
) (
  input  logic [AW-1:0] acc,
  input  logic [QW-1:0] mq,
  input  logic [AW-1:0] mcand,
  input  booth_op_e     op,
  output logic [AW-1:0] acc_nx,
  output logic [QW-1:0] mq_nx,
  output logic          prev_nx
);
  logic [AW-1:0] sum;

  always_comb begin
    unique case (op)
      OP_ADD:  sum = acc + mcand;
      OP_SUB:  sum = acc - mcand;
      default: sum = acc;
    endcase
    acc_nx  = {sum[AW-1], sum[AW-1:1]};
    mq_nx   = {sum[0], mq[QW-1:1]};
    prev_nx = mq[0];
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mode_in,
  output logic busy,
  output logic done,
  output logic load_en,
  output logic step_en,
  output logic mode_q
);
  localparam int CW = $clog2(W + 2);
  localparam logic [CW-1:0] LAST_S = CW'(W - 1);
  localparam logic [CW-1:0] LAST_U = CW'(W);

  booth_state_e  state_q, state_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic          mode_nx, done_q, done_nx, finish;

  always_comb begin
    load_en  = (state_q == ST_IDLE) && start;
    step_en  = (state_q == ST_RUN);
    finish   = step_en && (cnt_q == (mode_q ? LAST_U : LAST_S));
    state_nx = state_q;
    cnt_nx   = cnt_q;
    mode_nx  = mode_q;
    done_nx  = finish;
    if (load_en) begin
      state_nx = ST_RUN;
      cnt_nx   = '0;
      mode_nx  = mode_in;
    end else if (step_en) begin
      cnt_nx = cnt_q + 1'b1;
      if (finish) state_nx = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nx;
      done_q  <= done_nx;
      if (load_en || step_en) begin
        cnt_q  <= cnt_nx;
        mode_q <= mode_nx;
      end
    end
  end

  assign busy = (state_q == ST_RUN);
  assign done = done_q;
endmodule

// File: rtl/booth_mult_seq.sv
module booth_mult_seq
  import booth_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         mode_unsigned,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] prod_lo
);
  localparam int QW = W + 1;
  localparam int AW = W + 2;
  localparam int FW = AW + QW;

  logic          rst_sync_n;
  logic          load_en, step_en, mode_q;
  logic [AW-1:0] acc_q, acc_nx, acc_step;
  logic [QW-1:0] mq_q, mq_nx, mq_step;
  logic [AW-1:0] mcand_q, mcand_nx;
  logic          prev_q, prev_nx, prev_step;
  booth_op_e     op;
  logic [FW-1:0] full;
  logic [2*W-1:0] prod;
  logic          spare_unused;

  booth_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  booth_ctrl #(.W(W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .mode_in (mode_unsigned),
    .busy    (busy),
    .done    (done),
    .load_en (load_en),
    .step_en (step_en),
    .mode_q  (mode_q)
  );

  booth_recode u_rec (
    .cur_bit  (mq_q[0]),
    .prev_bit (prev_q),
    .op       (op)
  );

  booth_step #(.AW(AW), .QW(QW)) u_step (
    .acc     (acc_q),
    .mq      (mq_q),
    .mcand   (mcand_q),
    .op      (op),
    .acc_nx  (acc_step),
    .mq_nx   (mq_step),
    .prev_nx (prev_step)
  );

  // next-state selection for the datapath
  always_comb begin
    acc_nx   = acc_q;
    mq_nx    = mq_q;
    prev_nx  = prev_q;
    mcand_nx = mcand_q;
    if (load_en) begin
      acc_nx   = '0;
      mq_nx    = {~mode_unsigned & op_b[W-1], op_b};
      prev_nx  = 1'b0;
      mcand_nx = {{2{~mode_unsigned & op_a[W-1]}}, op_a};
    end else if (step_en) begin
      acc_nx  = acc_step;
      mq_nx   = mq_step;
      prev_nx = prev_step;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q   <= '0;
      mq_q    <= '0;
      prev_q  <= 1'b0;
      mcand_q <= '0;
    end else if (load_en || step_en) begin
      acc_q   <= acc_nx;
      mq_q    <= mq_nx;
      prev_q  <= prev_nx;
      mcand_q <= mcand_nx;
    end
  end

  // Signed runs W steps, leaving the product one place higher than unsigned runs.
  assign full = {acc_q, mq_q};

  generate
    if (FW > 2 * W + 1) begin : g_spare
      assign spare_unused = ^full[FW-1:2*W+1];
    end else begin : g_nospare
      assign spare_unused = 1'b0;
    end
  endgenerate

  assign prod    = mode_q ? full[2*W-1:0] : full[2*W:1];
  assign prod_hi = prod[2*W-1:W];
  assign prod_lo = prod[W-1:0];
endmodule

// File: rtl/booth_mult_seq_chk.sv
module booth_mult_seq_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         mode_unsigned,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] prod_hi,
  input logic [W-1:0] prod_lo
);
  localparam int CW = $clog2(W + 3);
  localparam logic [CW-1:0] LAT_S = CW'(W);
  localparam logic [CW-1:0] LAT_U = CW'(W + 1);

  logic [CW-1:0] lat_q;
  logic          lat_mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q      <= '0;
      lat_mode_q <= 1'b0;
    end else if (start && !busy) begin
      lat_q      <= '0;
      lat_mode_q <= mode_unsigned;
    end else if (busy) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy)); // R6
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == (lat_mode_q ? LAT_U : LAT_S))); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable({prod_hi, prod_lo})); // R7
endmodule

bind booth_mult_seq booth_mult_seq_chk #(.W(W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .start         (start),
  .mode_unsigned (mode_unsigned),
  .busy          (busy),
  .done          (done),
  .prod_hi       (prod_hi),
  .prod_lo       (prod_lo)
);

// File: tb/booth_mult_seq_tb.sv
module booth_mult_seq_tb;
  localparam int W = 32;

  typedef struct {
    logic [63:0] prod;
    int          start_cyc;
    logic        umode;
    string       tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         mode_unsigned;
  logic [W-1:0] op_a, op_b;
  logic         busy, done;
  logic [W-1:0] prod_hi, prod_lo;

  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 0;
  bit          prev_done = 0;
  logic [63:0] last_prod = '0;
  logic [31:0] seed = 32'h1234_5678;
  exp_t        sb[$];
  exp_t        got_item;

  booth_mult_seq #(.W(W)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .mode_unsigned (mode_unsigned),
    .op_a          (op_a),
    .op_b          (op_b),
    .busy          (busy),
    .done          (done),
    .prod_hi       (prod_hi),
    .prod_lo       (prod_lo)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // monitor: pops the scoreboard whenever a product is announced
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        if (sb.size() == 0) begin
          check("R2 extra done", 64'd1, 64'd0);
        end else begin
          got_item = sb.pop_front();
          check(got_item.tag, {prod_hi, prod_lo}, got_item.prod);
          check(got_item.umode ? "R5 latency unsigned" : "R5 latency signed",
                64'(cyc - got_item.start_cyc), got_item.umode ? 64'd33 : 64'd32);
          last_prod = got_item.prod;
        end
        check("R6 busy low with done", {63'd0, busy}, 64'd0);
        check("R6 done single cycle", {63'd0, prev_done}, 64'd0);
      end
      prev_done = done;
    end
  end

  // driver: pushes expected item, pulses start, optionally disturbs the run
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic um,
                        input bit poke, input string tag);
    exp_t it;
    while (busy) @(negedge clk);
    it.umode = um;
    it.tag = tag;
    if (um) it.prod = {32'd0, a} * {32'd0, b};
    else    it.prod = {{32{a[31]}}, a} * {{32{b[31]}}, b};
    it.start_cyc = cyc + 1;
    sb.push_back(it);
    op_a = a; op_b = b; mode_unsigned = um; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after start", {63'd0, busy}, 64'd1);
    // R8: scramble sampled inputs during the run
    op_a = ~a ^ 32'h5a5a_0f0f; op_b = b + 32'd77; mode_unsigned = ~um;
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1'b1;           // R2: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mode_unsigned = 1'b0; op_a = '0; op_b = '0;
    repeat (2) @(negedge clk);
    check("R1 busy in reset", {63'd0, busy}, 64'd0);
    check("R1 product in reset", {prod_hi, prod_lo}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 busy after reset", {63'd0, busy}, 64'd0);
    check("R1 done after reset", {63'd0, done}, 64'd0);
    check("R1 product after reset", {prod_hi, prod_lo}, 64'd0);

    run_op(32'd7, 32'd3, 1'b0, 0, "R3 7*3");
    run_op(32'd7, -32'sd3, 1'b0, 0, "R3 7*-3");
    run_op(-32'sd7, 32'd3, 1'b0, 0, "R3 -7*3");
    run_op(-32'sd7, -32'sd3, 1'b0, 0, "R3 -7*-3");
    run_op(32'd20, 32'd30, 1'b0, 0, "R3 20*30");
    run_op(32'd0, 32'hdead_beef, 1'b0, 0, "R3 zero");
    run_op(32'h8000_0000, 32'h8000_0000, 1'b0, 0, "R9 min*min");
    run_op(32'h8000_0000, 32'hffff_ffff, 1'b0, 0, "R9 min*-1");
    run_op(32'h8000_0000, 32'h7fff_ffff, 1'b0, 0, "R9 min*max");
    run_op(32'h7fff_ffff, 32'h7fff_ffff, 1'b0, 0, "R9 max*max");
    run_op(32'hffff_ffff, 32'hffff_ffff, 1'b1, 0, "R9 unsigned ones*ones");
    run_op(32'h8000_0000, 32'd2, 1'b1, 0, "R4 unsigned 2^31*2");
    run_op(32'hffff_ffff, 32'd1, 1'b1, 0, "R4 unsigned ones*1");
    run_op(32'd7, 32'd3, 1'b1, 0, "R4 unsigned 7*3");
    run_op(32'h1234_5678, 32'h9abc_def0, 1'b0, 1, "R2 R8 signed poked");
    run_op(32'hfedc_ba98, 32'h8765_4321, 1'b1, 1, "R2 R8 unsigned poked");

    // R7: product holds while idle inputs wander
    for (int k = 0; k < 4; k++) begin
      op_a = lcg(seed); op_b = ~op_a; mode_unsigned = k[0];
      @(negedge clk);
    end
    check("R7 product held", {prod_hi, prod_lo}, last_prod);

    for (int i = 0; i < 40; i++) begin
      logic [31:0] ra, rb;
      seed = lcg(seed); ra = seed;
      seed = lcg(seed); rb = seed;
      run_op(ra, rb, i[0], (i % 7) == 3, i[0] ? "R4 random" : "R3 random");
    end
    repeat (3) @(negedge clk);
    check("R6 all results seen", 64'(sb.size()), 64'd0);
    finished = 1;
    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end
endmodule